// File: doc/BRIEF.md
# Stereo Channel Mixer with Attenuation and Zero-Run Muting

This block sits in the digital audio path ahead of the filters. It takes one stereo sample pair per valid strobe and returns one processed pair a cycle later. A 4-bit routing code chooses what each output carries: silence, the left input, the right input, or the average of the two. Each output is then scaled by an 8-bit linear gain code, and then by a soft-mute level that ramps between unity and silence.

The gain codes arrive from a register file as staged values. They take effect only when the matching load-enable input is high. A shared-gain input makes the left gain govern both channels. A run detector watches for long stretches of digital silence on both inputs. Its flag, gated by an enable, joins the register mute bit and an external mute line to form the soft-mute request.

Top module: `chmix_top`

## Requirements
- R1: `route_code[1:0]` selects the left output and `route_code[3:2]` selects the right output. In each pair, 00 gives zero, 01 the left input, 10 the right input and 11 the average. Code 1001 therefore passes stereo straight through.
- R2: The average is floor((L+R)/2), computed one bit wider than the samples. It never wraps, even with both inputs at full positive or full negative scale.
- R3: A gain code c scales a sample x to floor(x*c/256), except that c = 0xFF is exact unity. Code 0x00 gives zero. The soft-mute level applies a second scaling by the same rule after the gain.
- R4: A gain register takes its staged code at the clock edge where its load input is high, and holds it otherwise. A sample that is valid in that same cycle still uses the old gain.
- R5: With `att_common` high, the applied left gain scales both outputs. With it low, each output uses its own applied gain.
- R6: After reset, both applied gains and the soft-mute level are 0xFF (unity), and `out_valid`, both outputs and `automute` are 0.
- R7: `automute` rises at the clock edge that accepts the 1024th consecutive valid sample with both inputs zero, and stays high while zero samples continue.
- R8: A valid sample with either input nonzero clears the zero-run count and drops `automute` at that same edge.
- R9: The soft-mute request is `mute_reg | mute_ext | (automute & zdet_en)`, taken from before the current sample. While it is high, each valid sample lowers the mute level by one code, down to 0. The sample uses the level held before its own step, so the 256th sample after a request starts at full level comes out zero.
- R10: While the request is low, each valid sample raises the mute level by one code, up to 0xFF.
- R11: `out_valid` follows `in_valid` one cycle later. Without a valid strobe, the outputs, mute level and zero-run count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | DW | Left input sample, two's complement |
| in_right | input | DW | Right input sample, two's complement |
| route_code | input | 4 | Output routing selection |
| att_left_code | input | GW | Staged left gain code |
| att_right_code | input | GW | Staged right gain code |
| ld_left | input | 1 | Load staged left code into applied gain |
| ld_right | input | 1 | Load staged right code into applied gain |
| att_common | input | 1 | Use left gain for both channels |
| mute_reg | input | 1 | Register soft-mute request |
| mute_ext | input | 1 | External soft-mute request |
| zdet_en | input | 1 | Lets the zero-run flag request soft mute |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | DW | Left output sample |
| out_right | output | DW | Right output sample |
| automute | output | 1 | Zero-run flag |

## Verification
Two events can share one clock edge: a gain load and a valid sample. When they do, the sample must be scaled by the gain applied before the load, and the next sample by the new one. The bench drives load-enable and the sample strobe together, both in directed steps and at random points during long random runs. It judges each output against a reference model that updates its gain state only after computing the expected sample. A second overlap gets the same treatment: the first nonzero sample after a zero run, where the flag clears while the ramp still steps on the old request.

// File: rtl/chmix_pkg.sv
`timescale 1ns/1ps
package chmix_pkg;
    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_LEFT  = 2'b01,
        SRC_RIGHT = 2'b10,
        SRC_AVG   = 2'b11
    } src_sel_e;
endpackage

// File: rtl/chmix_route.sv
`timescale 1ns/1ps
module chmix_route
    import chmix_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic [DW-1:0] left_in,
    input  logic [DW-1:0] right_in,
    input  logic [1:0]    sel,
    output logic [DW-1:0] mix_out
);
    // one bit of headroom for the average (R2)
    logic [DW:0] sum_w;

    always_comb begin
        sum_w = {left_in[DW-1], left_in} + {right_in[DW-1], right_in};
        unique case (src_sel_e'(sel))
            SRC_NONE:  mix_out = '0;
            SRC_LEFT:  mix_out = left_in;
            SRC_RIGHT: mix_out = right_in;
            default:   mix_out = sum_w[DW:1];
        endcase
    end
endmodule

// File: rtl/chmix_scale.sv
`timescale 1ns/1ps
module chmix_scale #(
    parameter int DW = 24,
    parameter int GW = 8
) (
    input  logic [DW-1:0] x_in,
    input  logic [GW-1:0] code,
    output logic [DW-1:0] y_out
);
    localparam int PW = DW + GW + 2;

    logic [GW:0]          gain_w;
    logic signed [PW-1:0] x_ext;
    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] prod_w;
    logic signed [PW-1:0] shr_w;

    always_comb begin
        // all-ones code means exact unity
        gain_w = (code == '1) ? {1'b1, {GW{1'b0}}} : {1'b0, code};
        x_ext  = PW'($signed(x_in));
        g_ext  = $signed({{(PW-GW-1){1'b0}}, gain_w});
        prod_w = x_ext * g_ext;
        shr_w  = prod_w >>> GW;
        y_out  = shr_w[DW-1:0];
    end
endmodule

// File: rtl/chmix_zero_det.sv
`timescale 1ns/1ps
module chmix_zero_det #(
    parameter int ZCNT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic is_zero,
    output logic flag
);
    localparam int CNTW = $clog2(ZCNT + 1);
    localparam logic [CNTW-1:0] CNT_TOP = CNTW'(ZCNT);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            hit;
    } zst_t;

    zst_t z_d, z_q;

    always_comb begin
        z_d = z_q;
        if (valid) begin
            if (is_zero) begin
                if (z_q.cnt != CNT_TOP) z_d.cnt = z_q.cnt + 1'b1;
                z_d.hit = (z_d.cnt == CNT_TOP);
            end else begin
                z_d.cnt = '0;
                z_d.hit = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) z_q <= '0;
        else        z_q <= z_d;
    end

    assign flag = z_q.hit;
endmodule

// File: rtl/chmix_top.sv
`timescale 1ns/1ps
module chmix_top
    import chmix_pkg::*;
#(
    parameter int DW   = 24,
    parameter int GW   = 8,
    parameter int ZCNT = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_left,
    input  logic [DW-1:0] in_right,
    input  logic [3:0]    route_code,
    input  logic [GW-1:0] att_left_code,
    input  logic [GW-1:0] att_right_code,
    input  logic          ld_left,
    input  logic          ld_right,
    input  logic          att_common,
    input  logic          mute_reg,
    input  logic          mute_ext,
    input  logic          zdet_en,
    output logic          out_valid,
    output logic [DW-1:0] out_left,
    output logic [DW-1:0] out_right,
    output logic          automute
);
    localparam int NCH = 2;
    localparam logic [GW-1:0] LVL_FULL = '1;

    typedef struct packed {
        logic [GW-1:0] gain_l;
        logic [GW-1:0] gain_r;
        logic [GW-1:0] ramp;
        logic          vld;
        logic [DW-1:0] y_l;
        logic [DW-1:0] y_r;
    } st_t;

    st_t s_d, s_q;

    logic [NCH-1:0][DW-1:0] mix_w;
    logic [NCH-1:0][GW-1:0] att_sel;
    logic [NCH-1:0][DW-1:0] att_w;
    logic [NCH-1:0][DW-1:0] fin_w;
    logic                   zflag;
    logic                   mute_req;
    logic                   both_zero;

    assign att_sel[0] = s_q.gain_l;
    assign att_sel[1] = att_common ? s_q.gain_l : s_q.gain_r;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            chmix_route #(.DW(DW)) i_route (
                .left_in  (in_left),
                .right_in (in_right),
                .sel      (route_code[2*c+1 -: 2]),
                .mix_out  (mix_w[c])
            );
            chmix_scale #(.DW(DW), .GW(GW)) i_att (
                .x_in  (mix_w[c]),
                .code  (att_sel[c]),
                .y_out (att_w[c])
            );
            chmix_scale #(.DW(DW), .GW(GW)) i_ramp (
                .x_in  (att_w[c]),
                .code  (s_q.ramp),
                .y_out (fin_w[c])
            );
        end
    endgenerate

    assign both_zero = (in_left == '0) && (in_right == '0);

    chmix_zero_det #(.ZCNT(ZCNT)) i_zdet (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (in_valid),
        .is_zero (both_zero),
        .flag    (zflag)
    );

    assign mute_req = mute_reg | mute_ext | (zflag & zdet_en);

    always_comb begin
        s_d     = s_q;
        s_d.vld = in_valid;
        if (ld_left)  s_d.gain_l = att_left_code;
        if (ld_right) s_d.gain_r = att_right_code;
        if (in_valid) begin
            s_d.y_l = fin_w[0];
            s_d.y_r = fin_w[1];
            if (mute_req) begin
                if (s_q.ramp != '0) s_d.ramp = s_q.ramp - 1'b1;
            end else begin
                if (s_q.ramp != LVL_FULL) s_d.ramp = s_q.ramp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.gain_l <= LVL_FULL;
            s_q.gain_r <= LVL_FULL;
            s_q.ramp   <= LVL_FULL;
            s_q.vld    <= 1'b0;
            s_q.y_l    <= '0;
            s_q.y_r    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.vld;
    assign out_left  = s_q.y_l;
    assign out_right = s_q.y_r;
    assign automute  = zflag;
endmodule

// File: rtl/chmix_checker.sv
`timescale 1ns/1ps
module chmix_checker #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] in_left,
    input logic [DW-1:0] in_right,
    input logic [3:0]    route_code,
    input logic          out_valid,
    input logic [DW-1:0] out_left,
    input logic [DW-1:0] out_right,
    input logic          automute
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

    a_r1_route_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_code == 4'b0000) |=> (out_left == '0 && out_right == '0));

    a_r7_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(automute) |-> $past(in_valid && in_left == '0 && in_right == '0));

    a_r8_clear_on_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_left != '0 || in_right != '0)) |=> !automute);

    a_r11_flag_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && automute) |=> automute);
endmodule

bind chmix_top chmix_checker #(.DW(DW)) i_chmix_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_left    (in_left),
    .in_right   (in_right),
    .route_code (route_code),
    .out_valid  (out_valid),
    .out_left   (out_left),
    .out_right  (out_right),
    .automute   (automute)
);

// File: tb/test_chmix_top.sv
`timescale 1ns/1ps
module test_chmix_top;
    localparam int DW = 24;
    localparam int GW = 8;
    localparam int ZC = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_left = '0;
    logic [DW-1:0] in_right = '0;
    logic [3:0]    route = 4'b1001;
    logic [GW-1:0] attl = 8'hFF;
    logic [GW-1:0] attr = 8'hFF;
    logic          ldl = 1'b0;
    logic          ldr = 1'b0;
    logic          common = 1'b0;
    logic          mreg = 1'b0;
    logic          mext = 1'b0;
    logic          zen = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_left;
    logic [DW-1:0] out_right;
    logic          automute;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    int     m_gl = 255, m_gr = 255, m_ramp = 255, m_cnt = 0;
    bit     m_am = 1'b0;
    longint exp_l = 0, exp_r = 0;

    always #2.5 clk = ~clk;

    chmix_top #(.DW(DW), .GW(GW), .ZCNT(ZC)) i_chmix_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .route_code(route), .att_left_code(attl),
        .att_right_code(attr), .ld_left(ldl), .ld_right(ldr),
        .att_common(common), .mute_reg(mreg), .mute_ext(mext), .zdet_en(zen),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .automute(automute)
    );

    function automatic longint sx(logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint scale(longint x, int code);
        longint g = (code == 255) ? 256 : code;
        return (x * g) >>> 8;
    endfunction

    function automatic longint pick(logic [1:0] s, longint a, longint b);
        case (s)
            2'b00:   return 0;
            2'b01:   return a;
            2'b10:   return b;
            default: return (a + b) >>> 1;
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic step(bit v, logic [DW-1:0] l, logic [DW-1:0] r, bit dl, bit dr, string tag);
        longint el, er;
        bit     req;
        @(negedge clk);
        in_valid = v; in_left = l; in_right = r; ldl = dl; ldr = dr;
        if (v) begin
            el = scale(scale(pick(route[1:0], sx(l), sx(r)), m_gl), m_ramp);
            er = scale(scale(pick(route[3:2], sx(l), sx(r)), common ? m_gl : m_gr), m_ramp);
        end else begin
            el = exp_l; er = exp_r;
        end
        @(posedge clk);
        #1;
        req = mreg | mext | (m_am & zen);
        if (v) begin
            if (l == '0 && r == '0) begin
                if (m_cnt < ZC) m_cnt++;
                m_am = (m_cnt == ZC);
            end else begin
                m_cnt = 0; m_am = 1'b0;
            end
            if (req && m_ramp > 0) m_ramp--;
            else if (!req && m_ramp < 255) m_ramp++;
        end
        if (dl) m_gl = int'(attl);
        if (dr) m_gr = int'(attr);
        exp_l = el; exp_r = er;
        check(out_valid == v && sx(out_left) == el && sx(out_right) == er && automute == m_am, tag,
              $sformatf("vld=%0b L=%0d R=%0d am=%0b expected vld=%0b L=%0d R=%0d am=%0b",
                        out_valid, sx(out_left), sx(out_right), automute, v, el, er, m_am));
        ldl = 1'b0; ldr = 1'b0;
    endtask

    function automatic logic [DW-1:0] rnd();
        return DW'($urandom());
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1;
        // R6: reset state
        check(out_valid == 0 && out_left == '0 && out_right == '0 && automute == 0, "R6",
              $sformatf("vld=%0b L=%0d R=%0d am=%0b expected all 0", out_valid, sx(out_left), sx(out_right), automute));
        @(negedge clk) rst_n = 1'b1;

        // R6: unity gains after reset, stereo route
        step(1, 24'h123456, 24'hFEDCBA, 0, 0, "R6_unity");

        // R1: every routing code
        for (int k = 0; k < 16; k++) begin
            route = 4'(k);
            step(1, rnd(), rnd(), 0, 0, "R1_route");
        end
        // R2: average at both extremes
        route = 4'b1111;
        step(1, 24'h7FFFFF, 24'h7FFFFF, 0, 0, "R2_max");
        step(1, 24'h800000, 24'h800000, 0, 0, "R2_min");
        step(1, 24'h000001, 24'hFFFFFE, 0, 0, "R2_floor");
        route = 4'b1001;

        // R4: staged code without load has no effect
        attl = 8'h80; attr = 8'h40;
        step(1, 24'h100000, 24'h100000, 0, 0, "R4_noload");
        // R4: load and sample in same cycle, sample uses old gain
        step(1, 24'h100000, 24'h100000, 1, 1, "R4_same_cycle");
        step(1, 24'h100000, 24'hF00000, 0, 0, "R4_new_gain");
        // R3: zero and minimum codes
        attl = 8'h00; attr = 8'h01;
        step(1, 24'h7FFFFF, 24'h7FFFFF, 1, 1, "R3_load");
        step(1, 24'h7FFFFF, 24'h800000, 0, 0, "R3_zero_min");
        // R5: shared gain
        attl = 8'h20; attr = 8'hC0;
        step(0, '0, '0, 1, 1, "R11_idle_load");
        common = 1'b1;
        step(1, 24'h654321, 24'h9ABCDE, 0, 0, "R5_common");
        common = 1'b0;
        step(1, 24'h654321, 24'h9ABCDE, 0, 0, "R5_separate");

        // R3 / R4 / R5 random mix with loads at random points
        for (int k = 0; k < 400; k++) begin
            route  = 4'($urandom());
            common = 1'($urandom());
            attl   = 8'($urandom());
            attr   = 8'($urandom());
            if ($urandom_range(0, 5) == 0) step(0, rnd(), rnd(), 1'($urandom()), 1'($urandom()), "R11_random_idle");
            else step(1, rnd(), rnd(), 1'($urandom()), 1'($urandom()), "R3_random");
        end

        // R9 / R10: soft mute ramp via register bit then external line
        attl = 8'hFF; attr = 8'hFF; route = 4'b1001; common = 1'b0;
        step(1, rnd(), rnd(), 1, 1, "R9_prep");
        while (m_ramp != 255) step(1, rnd(), rnd(), 0, 0, "R10_prep");
        mreg = 1'b1;
        for (int k = 0; k < 260; k++) step(1, 24'h7FFFFF, 24'h800000, 0, 0, "R9_ramp_down");
        mreg = 1'b0;
        for (int k = 0; k < 260; k++) step(1, rnd(), rnd(), 0, 0, "R10_ramp_up");
        mext = 1'b1;
        for (int k = 0; k < 40; k++) step(1, rnd(), rnd(), 0, 0, "R9_ext");
        mext = 1'b0;
        for (int k = 0; k < 40; k++) step(1, rnd(), rnd(), 0, 0, "R10_ext");
        while (m_ramp != 255) step(1, rnd(), rnd(), 0, 0, "R10_settle");

        // R7: zero run with detector gating enabled
        zen = 1'b1;
        for (int k = 0; k < ZC - 1; k++) step(1, '0, '0, 0, 0, "R7_run");
        step(0, '0, '0, 0, 0, "R11_idle_hold");
        step(1, '0, '0, 0, 0, "R7_set");
        for (int k = 0; k < 20; k++) step(1, '0, '0, 0, 0, "R9_auto_ramp");
        // R8: nonzero clears flag, ramp continues on old request for this sample
        step(1, 24'h000001, '0, 0, 0, "R8_clear");
        for (int k = 0; k < ZC - 1; k++) step(1, '0, '0, 0, 0, "R8_recount");
        step(1, 24'h400000, 24'h400000, 0, 0, "R8_no_flag");
        while (m_ramp != 255) step(1, rnd(), rnd(), 0, 0, "R10_recover");

        // R9: flag without gating leaves output at full level
        zen = 1'b0;
        for (int k = 0; k < ZC; k++) step(1, '0, '0, 0, 0, "R7_ungated");
        step(1, 24'h7FFFFF, 24'h7FFFFF, 0, 0, "R9_ungated");
        step(1, 24'h7FFFFF, 24'h7FFFFF, 0, 0, "R9_ungated_next");

        step(0, '0, '0, 0, 0, "R11_end");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule